// File: doc/BRIEF.md
# Isolated-Toggle Swap Byte Encoder

This block prepares bytes for a single-wire serial link so that the wire toggles less often. Each accepted byte is read as a bit sequence a0..a7, where a0 is port bit 0 and is the first bit to go onto the wire. The block looks for isolated toggles, which are three-bit windows whose first and last bits match while the middle bit differs. In each such window it exchanges the last two bits, so 010 becomes 001 and 101 becomes 110.

The scan runs from the low end of the byte. After a swap it skips ahead so that no two rewritten windows overlap. Two side-band flags mark the regions of the byte that were rewritten, which lets a receiver undo the swaps. One flag covers windows that start at positions 0 to 2, and the other covers windows that start at positions 3 to 5.

A serializer-side source hands over one byte per valid/ready handshake. The encoded byte and its two flags come out of one register stage, all aligned, one clock after acceptance.

Top module: `tsq_encoder`

## Requirements
- R1: Window start positions i run from 0 to 5 over a(i) = in_data[i]. A window is a candidate when a(i) equals a(i+2) and a(i+1) differs from a(i).
- R2: For each selected window, output bit i+1 takes a(i+2) and output bit i+2 takes a(i+1). Every bit outside the selected windows passes through unchanged.
- R3: When no window is selected, out_data equals the accepted byte and both flags are 0.
- R4: out_flag_front is 1 exactly when a selected window starts at a position below 3. out_flag_back is 1 exactly when a selected window starts at position 3 or higher.
- R5: The scan starts at i = 0. After a selection at i, the next window examined starts at i+3. Without a selection, the scan moves to i+1. Two selected windows therefore never overlap or touch.
- R6: out_valid is 1 in the cycle after a handshake (in_valid and in_ready both 1 at a clock edge), and 0 in the cycle after an edge without one. Back-to-back handshakes produce back-to-back outputs.
- R7: out_data and both flags keep their values across edges with no handshake.
- R8: The number of adjacent-bit transitions within out_data never exceeds the number within the byte it came from.
- R9: A synchronous active-high reset clears out_valid, out_data, both flags and in_ready. Reset takes priority over a handshake on the same edge.
- R10: in_ready is 1 from the first edge after reset is released, for as long as reset stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers a byte |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | DATA_W | Byte to encode, bit 0 sent first |
| out_valid | output | 1 | Encoded byte present this cycle |
| out_data | output | DATA_W | Encoded byte |
| out_flag_front | output | 1 | A window starting below 3 was swapped |
| out_flag_back | output | 1 | A window starting at 3 or above was swapped |

## Verification
The hardest case to reach from the ports is a byte that holds a candidate window the scan must skip, because it overlaps a window already swapped. One example is 0101..., where the 101 window at position 1 is never rewritten. The table of directed vectors holds several such bytes. The complete sweep of all 256 input values then reaches every chain of overlapping candidates, and each result is compared with an independent step-by-step scan model and with the transition-count bound.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  // Three-bit window examined by the scan.
  localparam int WIN_LEN = 3;

  // Isolated toggle: ends equal, middle differs.
  function automatic logic is_isolated(logic first, logic mid, logic last);
    return (first == last) && (mid != first);
  endfunction

  // Region flags carried next to each encoded byte.
  typedef struct packed {
    logic front;
    logic back;
  } region_flags_t;

endpackage

// File: rtl/tsq_window_detect.sv
module tsq_window_detect #(
  parameter int DATA_W = 8,
  localparam int NPOS = DATA_W - tsq_pkg::WIN_LEN + 1
) (
  input  logic [DATA_W-1:0] din,
  output logic [NPOS-1:0]   cand
);

  for (genvar gi = 0; gi < NPOS; gi++) begin : g_win
    assign cand[gi] = tsq_pkg::is_isolated(din[gi], din[gi+1], din[gi+2]);
  end

endmodule

// File: rtl/tsq_scan_chain.sv
module tsq_scan_chain #(
  parameter int NPOS = 6
) (
  input  logic [NPOS-1:0] cand,
  output logic [NPOS-1:0] take
);

  // A selection at position i hides positions i+1 and i+2 from the scan.
  logic [NPOS-1:0] take_v;
  logic            hit1;
  logic            hit2;
  logic            cur;

  always_comb begin
    take_v = '0;
    hit1   = 1'b0;
    hit2   = 1'b0;
    cur    = 1'b0;
    for (int i = 0; i < NPOS; i++) begin
      cur       = cand[i] & ~hit1 & ~hit2;
      take_v[i] = cur;
      hit2      = hit1;
      hit1      = cur;
    end
  end

  assign take = take_v;

endmodule

// File: rtl/tsq_swap_net.sv
module tsq_swap_net #(
  parameter int DATA_W = 8,
  parameter int SPLIT  = 3,
  localparam int NPOS = DATA_W - tsq_pkg::WIN_LEN + 1
) (
  input  logic [DATA_W-1:0]     din,
  input  logic [NPOS-1:0]       take,
  output logic [DATA_W-1:0]     dout,
  output tsq_pkg::region_flags_t flags
);

  always_comb begin
    dout = din;
    for (int i = 0; i < NPOS; i++) begin
      if (take[i]) begin
        dout[i+1] = din[i+2];
        dout[i+2] = din[i+1];
      end
    end
  end

  assign flags.front = |take[SPLIT-1:0];
  assign flags.back  = |take[NPOS-1:SPLIT];

endmodule

// File: rtl/tsq_encoder.sv
module tsq_encoder #(
  parameter int DATA_W = 8,
  parameter int SPLIT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flag_front,
  output logic              out_flag_back
);

  localparam int NPOS = DATA_W - tsq_pkg::WIN_LEN + 1;

  logic                   ready_q;
  logic                   accept;
  logic [NPOS-1:0]        cand;
  logic [NPOS-1:0]        take;
  logic [DATA_W-1:0]      enc_data;
  tsq_pkg::region_flags_t enc_flags;
  tsq_pkg::region_flags_t flags_q;
  logic [DATA_W-1:0]      data_q;
  logic                   valid_q;

  assign accept = in_valid & ready_q;

  tsq_window_detect #(.DATA_W(DATA_W)) u_detect (
    .din  (in_data),
    .cand (cand)
  );

  tsq_scan_chain #(.NPOS(NPOS)) u_chain (
    .cand (cand),
    .take (take)
  );

  tsq_swap_net #(.DATA_W(DATA_W), .SPLIT(SPLIT)) u_swap (
    .din   (in_data),
    .take  (take),
    .dout  (enc_data),
    .flags (enc_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      flags_q <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= accept;
      if (accept) begin
        data_q  <= enc_data;
        flags_q <= enc_flags;
      end
    end
  end

  assign in_ready       = ready_q;
  assign out_valid      = valid_q;
  assign out_data       = data_q;
  assign out_flag_front = flags_q.front;
  assign out_flag_back  = flags_q.back;

endmodule

// File: rtl/tsq_encoder_chk.sv
module tsq_encoder_chk #(
  parameter int DATA_W = 8,
  parameter int SPLIT  = 3,
  localparam int NPOS = DATA_W - tsq_pkg::WIN_LEN + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              accept,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [NPOS-1:0]   take,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_flag_front,
  input logic              out_flag_back
);

  function automatic int unsigned flips(logic [DATA_W-1:0] v);
    int unsigned n = 0;
    for (int k = 0; k + 1 < DATA_W; k++) n += (v[k] != v[k+1]) ? 1 : 0;
    return n;
  endfunction

  // R6: output valid follows a handshake by one cycle
  a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  a_r6_idle_drops_valid: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !out_valid);

  // R7: outputs hold without a handshake
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(out_data) && $stable(out_flag_front) && $stable(out_flag_back)));

  // R3: nothing selected means pass-through with clear flags
  a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
    (accept && take == '0) |=> (out_data == $past(in_data) && !out_flag_front && !out_flag_back));

  // R8: transitions never grow
  a_r8_no_more_flips: assert property (@(posedge clk) disable iff (rst)
    accept |=> (flips(out_data) <= $past(flips(in_data))));

  // R5: selected windows never overlap or touch
  always_comb begin
    if (!rst) begin
      a_r5_spacing: assert ((take & (take >> 1)) == '0 && (take & (take >> 2)) == '0);
    end
  end

  // R9: reset clears the outputs
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && !out_flag_front && !out_flag_back && !in_ready));

  // R10: ready after reset release
  a_r10_ready: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_ready);

endmodule

bind tsq_encoder tsq_encoder_chk #(.DATA_W(DATA_W), .SPLIT(SPLIT)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .accept         (accept),
  .in_ready       (in_ready),
  .in_data        (in_data),
  .take           (take),
  .out_valid      (out_valid),
  .out_data       (out_data),
  .out_flag_front (out_flag_front),
  .out_flag_back  (out_flag_back)
);

// File: tb/tsq_encoder_bench.sv
module tsq_encoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_flag_front;
  logic       out_flag_back;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsq_encoder u_tsq_encoder (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_data        (in_data),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .out_flag_front (out_flag_front),
    .out_flag_back  (out_flag_back)
  );

  // Vectors written in wire order a0..a7 (leftmost = a0): {in, out, front, back}
  localparam int NVEC = 9;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'b11111111, 8'b11111111, 2'b00},
    {8'b10101010, 8'b11000110, 2'b11},
    {8'b01010001, 8'b00110001, 2'b10},
    {8'b11001010, 8'b11000110, 2'b01},
    {8'b11010101, 8'b11100011, 2'b11},
    {8'b01010101, 8'b00111001, 2'b11},
    {8'b00000101, 8'b00000011, 2'b01},
    {8'b10100000, 8'b11000000, 2'b10},
    {8'b01011010, 8'b00111100, 2'b11}
  };

  function automatic logic [7:0] wire_to_port(logic [7:0] w);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = w[7-k];
    return p;
  endfunction

  function automatic int edges(logic [7:0] v);
    int n = 0;
    for (int k = 0; k < 7; k++) if (v[k] ^ v[k+1]) n++;
    return n;
  endfunction

  // Step-by-step scan, as the requirements describe it
  task automatic scan_model(input logic [7:0] a, output logic [7:0] b,
                            output logic ff, output logic fb);
    int i;
    b = a; ff = 1'b0; fb = 1'b0; i = 0;
    while (i <= 5) begin
      if (a[i] == a[i+2] && a[i+1] != a[i]) begin
        b[i+1] = a[i+2];
        b[i+2] = a[i+1];
        if (i < 3) ff = 1'b1; else fb = 1'b1;
        i = i + 3;
      end else begin
        i = i + 1;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [7:0] exp_d,
                           input logic exp_f, input logic exp_b);
    check(out_valid === 1'b1, {req, " valid"}, int'(out_valid), 1);
    check(out_data === exp_d, {req, " data"}, int'(out_data), int'(exp_d));
    check({out_flag_front, out_flag_back} === {exp_f, exp_b}, {req, " flags"},
          int'({out_flag_front, out_flag_back}), int'({exp_f, exp_b}));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] md;
    logic       mf, mb;
    logic [7:0] last_d;

    // R9: reset state, in_ready low in reset
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R9 reset valid", int'(out_valid), 0);
    check(out_data === 8'h00, "R9 reset data", int'(out_data), 0);
    check({out_flag_front, out_flag_back} === 2'b00, "R9 reset flags",
          int'({out_flag_front, out_flag_back}), 0);
    check(in_ready === 1'b0, "R9 reset ready", int'(in_ready), 0);

    rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R10 ready after release", int'(in_ready), 1);
    check(out_valid === 1'b0, "R6 idle no valid", int'(out_valid), 0);

    // Table of vectors, back to back (R1 R2 R4 R5 R6)
    for (int v = 0; v < NVEC; v++) begin
      in_valid = 1'b1;
      in_data  = wire_to_port(VEC[v][17:10]);
      @(negedge clk);
      check_out("R2 R4 R5 table", wire_to_port(VEC[v][9:2]), VEC[v][1], VEC[v][0]);
    end
    last_d = wire_to_port(VEC[NVEC-1][9:2]);

    // R6 R7: idle cycles drop valid and hold the data, even when in_data moves
    in_valid = 1'b0;
    in_data  = 8'h55;
    @(negedge clk);
    check(out_valid === 1'b0, "R6 valid drops", int'(out_valid), 0);
    check(out_data === last_d, "R7 data held", int'(out_data), int'(last_d));
    check({out_flag_front, out_flag_back} === 2'b11, "R7 flags held",
          int'({out_flag_front, out_flag_back}), 3);
    @(negedge clk);
    check(out_data === last_d, "R7 data held 2", int'(out_data), int'(last_d));

    // Full sweep against scan model (R1 R2 R3 R4 R5 R8)
    for (int x = 0; x < 256; x++) begin
      in_valid = 1'b1;
      in_data  = 8'(x);
      @(negedge clk);
      scan_model(8'(x), md, mf, mb);
      check_out("R1 R5 sweep", md, mf, mb);
      if (!mf && !mb) check(out_data === 8'(x), "R3 passthrough", int'(out_data), x);
      check(edges(out_data) <= edges(8'(x)), "R8 transitions", edges(out_data), edges(8'(x)));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R6 valid drops after sweep", int'(out_valid), 0);

    // R9: reset wins over a handshake on the same edge
    in_valid = 1'b1;
    in_data  = 8'hAA;
    rst      = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R9 reset over accept valid", int'(out_valid), 0);
    check(out_data === 8'h00, "R9 reset over accept data", int'(out_data), 0);
    rst      = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R10 ready again", int'(in_ready), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule